// File: doc/BRIEF.md
# USB Endpoint Packet Buffer Port

This block is the bus-facing side of a single-packet endpoint buffer in a USB device controller. A CPU or DMA engine moves packet bytes through a port: writes on a transmit pipe and reads on a receive pipe. The block keeps a byte counter and decides who owns the 64-byte buffer at each moment, the bus or the serial interface engine (SIE). On transmit, a packet is handed to the SIE once it is full. It can also be handed over early with an explicit end command or, in DMA mode, with an end-of-transfer strobe. On receive, the buffer goes back to the SIE once the bus has read every byte of the packet.

Software first picks a pipe. It then waits for the ready flag before it touches the port. Port accesses are 8 or 16 bits wide. A 16-bit access carries two bytes, with the lower address in the low byte. A zero-length packet is sent by clearing the buffer and then issuing the end command. A zero-length packet that arrives holds no readable data, so software gives its buffer back with the clear command. The SIE side is modelled as a simple handshake: an ownership flag, a committed length, a byte-wide buffer access port, a "sent" pulse and an "arrived" pulse that carries a length.

Top module: `usb_pkt_port`

## Requirements
- R1: After reset the selected pipe is 0 and the direction is transmit. `rdy` is 1 and `sie_own` is 0. `wr_err`, `rx_len` and `tx_len` are 0, and every buffer byte reads 0 on the SIE port.
- R2: A `sel_we` pulse loads `cur_pipe` from `sel_pipe` and forces `rdy` to 0 for the following cycle. The direction is latched at the same edge. Pipe 0 takes its direction from `ctrl_dir_tx` and every other pipe takes it from `pipe_dir_tx` (1 = transmit). A transmit pipe then shows `rdy`=1. A receive pipe shows `rdy`=0 and `sie_own`=1 until a packet arrives.
- R3: The packet limit is `max_pkt`, where the values 0 and anything above 64 both mean 64. When a write brings the count up to the limit, the packet is committed in the same cycle: `sie_own` becomes 1, `rdy` becomes 0 and `tx_len` equals the limit. A high byte that would go past the limit is discarded.
- R4: A `wend` pulse commits the bytes held so far, as a short packet. A `dma_end` pulse does the same only while `dma_mode` is 1. While `dma_mode` is 0 it has no effect.
- R5: A `bclr` pulse on a transmit pipe empties the count. A `wend` pulse that follows then commits a packet with `tx_len`=0.
- R6: In 16-bit mode (`wide16`=1), a write with `wr_hi_en`=1 stores `wr_data[7:0]` at the current count and `wr_data[15:8]` at the next address. With `wr_hi_en`=0 it stores only the low byte. In 8-bit mode, each write stores `wr_data[7:0]` alone.
- R7: A `sie_done` pulse while the SIE owns a transmit buffer returns the buffer to the bus. `rdy` goes back to 1, `tx_len` to 0, and the next write lands at address 0.
- R8: A `sie_rx_valid` pulse while the SIE owns a receive buffer loads `rx_len` from `sie_rx_len` and sets `rdy` to 1. Reads return bytes in address order. A 16-bit read returns two bytes, little-endian, with the high byte 0 if only one byte remains. An 8-bit read returns one byte, zero-extended. Reading the last byte gives the buffer back to the SIE.
- R9: When `rx_len` is 0, reads return 0 and do not release the buffer. Only `bclr` hands it back to the SIE.
- R10: A write while `rdy` is 0, or on a receive pipe, changes no data and sets the sticky `wr_err`. `bclr` clears `wr_err`. A read while `rdy` is 0, or on a transmit pipe, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_we | input | 1 | Pipe select strobe |
| sel_pipe | input | 3 | Pipe number to select |
| pipe_dir_tx | input | 1 | Configured direction of pipes 1..7 (1 = transmit) |
| ctrl_dir_tx | input | 1 | Direction of the control pipe 0 (1 = transmit) |
| wide16 | input | 1 | 1 = 16-bit port access, 0 = 8-bit |
| dma_mode | input | 1 | Enables the DMA end strobe |
| max_pkt | input | 7 | Maximum packet size, 0 means 64 |
| wr_en | input | 1 | Port write strobe |
| wr_hi_en | input | 1 | Upper byte lane enable for 16-bit writes |
| wr_data | input | 16 | Port write data |
| rd_en | input | 1 | Port read strobe |
| rd_data | output | 16 | Port read data, valid in the cycle of `rd_en` |
| wend | input | 1 | Write-end command |
| dma_end | input | 1 | DMA end-of-transfer strobe |
| bclr | input | 1 | Buffer-clear command |
| rdy | output | 1 | Bus may access the port |
| wr_err | output | 1 | Sticky flag for an ignored write |
| rx_len | output | 7 | Length of the received packet |
| cur_pipe | output | 3 | Currently selected pipe |
| sie_own | output | 1 | Buffer is held by the SIE |
| tx_len | output | 7 | Length of the committed transmit packet |
| sie_done | input | 1 | SIE finished sending the packet |
| sie_rx_valid | input | 1 | SIE has stored a received packet |
| sie_rx_len | input | 7 | Length of the received packet |
| sie_we | input | 1 | SIE buffer write strobe |
| sie_addr | input | 6 | SIE buffer address |
| sie_wdata | input | 8 | SIE buffer write data |
| sie_rdata | output | 8 | SIE buffer read data |

## Verification
The bench goes after the last byte before the limit. There, a two-byte write must store one byte and commit. A design that ignored the limit would overrun into the next packet, and one that dropped the whole access would lose data. It also sends zero-length packets both ways. A transmit design that could not commit with a count of 0 would hang. A receive design that counted a zero-length read as the last byte would free the buffer without `bclr`. Odd-length receive packets read in 16-bit mode check that the unused high byte is 0 and that release happens exactly once. Writes and reads issued in the settle cycle after a select, or against the wrong direction, must leave the buffer untouched and raise the sticky error.

// File: rtl/pkt_port_pkg.sv
package pkt_port_pkg;

    typedef enum logic {
        HOLDER_BUS = 1'b0,
        HOLDER_SIE = 1'b1
    } holder_e;

    // Effective packet limit: 0 or anything above the buffer depth means a full buffer.
    function automatic int unsigned pick_limit(input int unsigned mp, input int unsigned depth);
        if (mp == 0 || mp > depth) begin
            return depth;
        end
        return mp;
    endfunction

endpackage

// File: rtl/pkt_port_mem.sv
module pkt_port_mem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_lo,
    input  logic [AW-1:0] addr_lo,
    input  logic [7:0]    d_lo,
    input  logic          we_hi,
    input  logic [AW-1:0] addr_hi,
    input  logic [7:0]    d_hi,
    input  logic          sie_we,
    input  logic [AW-1:0] sie_addr,
    input  logic [7:0]    sie_wd,
    output logic [7:0]    q_lo,
    output logic [7:0]    q_hi,
    output logic [7:0]    sie_q
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (sie_we && sie_addr == AW'(i)) begin
                mem_d[i] = sie_wd;
            end
            if (we_lo && addr_lo == AW'(i)) begin
                mem_d[i] = d_lo;
            end
            if (we_hi && addr_hi == AW'(i)) begin
                mem_d[i] = d_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign q_lo  = mem_q[addr_lo];
    assign q_hi  = mem_q[addr_hi];
    assign sie_q = mem_q[sie_addr];

    // R6: the upper lane only ever writes together with the lower lane, one address above it
    a_r6_lane_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |-> (we_lo && addr_hi == addr_lo + AW'(1)));

    // R2: the bus and the SIE never write the buffer in the same cycle
    a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        sie_we |-> !we_lo);

endmodule

// File: rtl/pkt_port_ctrl.sv
module pkt_port_ctrl
    import pkt_port_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PIPES = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(PIPES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_we,
    input  logic [PW-1:0] sel_pipe,
    input  logic          pipe_dir_tx,
    input  logic          ctrl_dir_tx,
    input  logic          wide16,
    input  logic          dma_mode,
    input  logic [LW-1:0] max_pkt,
    input  logic          wr_en,
    input  logic          wr_hi_en,
    input  logic          rd_en,
    input  logic          wend,
    input  logic          dma_end,
    input  logic          bclr,
    input  logic          sie_done,
    input  logic          sie_rx_valid,
    input  logic [LW-1:0] sie_rx_len,
    input  logic          sie_we_req,
    output logic          sie_we_ok,
    output logic          bus_we_lo,
    output logic          bus_we_hi,
    output logic          rd_lo_en,
    output logic          rd_hi_en,
    output logic [AW-1:0] addr_lo,
    output logic [AW-1:0] addr_hi,
    output logic          rdy,
    output logic          wr_err,
    output logic [LW-1:0] rx_len,
    output logic [LW-1:0] tx_len,
    output logic [PW-1:0] cur_pipe,
    output logic          sie_own
);

    typedef struct packed {
        logic [PW-1:0] pipe;
        logic          dir_tx;
        holder_e       holder;
        logic          settle;
        logic [LW-1:0] cnt;
        logic [LW-1:0] rx_len;
        logic [LW-1:0] tx_len;
        logic          err;
    } state_t;

    state_t s_q, s_d;

    logic [LW-1:0] limit;
    logic [LW:0]   lim_x, cnt_x, rxl_x, wr_next, rd_next;
    logic          access_ok, quiet, wr_ok, rd_ok, wr_two, rd_two, commit_req;

    always_comb begin
        limit     = LW'(pick_limit(int'(max_pkt), DEPTH));
        lim_x     = {1'b0, limit};
        cnt_x     = {1'b0, s_q.cnt};
        rxl_x     = {1'b0, s_q.rx_len};
        access_ok = !s_q.settle && s_q.holder == HOLDER_BUS;
        quiet     = !sel_we && !bclr;
        wr_ok     = quiet && wr_en && access_ok && s_q.dir_tx;
        rd_ok     = quiet && rd_en && access_ok && !s_q.dir_tx && s_q.rx_len != '0;
        wr_two    = wide16 && wr_hi_en && (cnt_x + (LW+1)'(2) <= lim_x);
        rd_two    = wide16 && (cnt_x + (LW+1)'(2) <= rxl_x);
        wr_next   = cnt_x + (wr_two ? (LW+1)'(2) : (LW+1)'(1));
        rd_next   = cnt_x + (rd_two ? (LW+1)'(2) : (LW+1)'(1));
        commit_req = quiet && access_ok && s_q.dir_tx && (wend || (dma_mode && dma_end));
        addr_lo   = s_q.cnt[AW-1:0];
        addr_hi   = s_q.cnt[AW-1:0] + AW'(1);
        bus_we_lo = wr_ok;
        bus_we_hi = wr_ok && wr_two;
        rd_lo_en  = rd_ok;
        rd_hi_en  = rd_ok && rd_two;
        sie_we_ok = sie_we_req && !s_q.dir_tx && s_q.holder == HOLDER_SIE && !s_q.settle;

        s_d        = s_q;
        s_d.settle = 1'b0;

        if (sel_we) begin
            s_d.pipe   = sel_pipe;
            s_d.dir_tx = (sel_pipe == '0) ? ctrl_dir_tx : pipe_dir_tx;
            s_d.holder = s_d.dir_tx ? HOLDER_BUS : HOLDER_SIE;
            s_d.settle = 1'b1;
            s_d.cnt    = '0;
            s_d.rx_len = '0;
            s_d.tx_len = '0;
            s_d.err    = 1'b0;
        end else if (bclr) begin
            s_d.err = 1'b0;
            if (access_ok) begin
                s_d.cnt = '0;
                if (!s_q.dir_tx) begin
                    s_d.holder = HOLDER_SIE;
                end
            end
        end else begin
            if (wr_en && !wr_ok) begin
                s_d.err = 1'b1;
            end
            if (wr_ok) begin
                s_d.cnt = wr_next[LW-1:0];
            end
            if (wr_ok && wr_next >= lim_x) begin
                s_d.holder = HOLDER_SIE;
                s_d.tx_len = wr_next[LW-1:0];
            end else if (commit_req) begin
                s_d.holder = HOLDER_SIE;
                s_d.tx_len = wr_ok ? wr_next[LW-1:0] : s_q.cnt;
            end
            if (rd_ok) begin
                if (rd_next >= rxl_x) begin
                    s_d.holder = HOLDER_SIE;
                    s_d.cnt    = '0;
                end else begin
                    s_d.cnt = rd_next[LW-1:0];
                end
            end
            if (sie_done && s_q.dir_tx && s_q.holder == HOLDER_SIE) begin
                s_d.holder = HOLDER_BUS;
                s_d.cnt    = '0;
                s_d.tx_len = '0;
            end
            if (sie_rx_valid && !s_q.dir_tx && s_q.holder == HOLDER_SIE && !s_q.settle) begin
                s_d.holder = HOLDER_BUS;
                s_d.cnt    = '0;
                s_d.rx_len = (int'(sie_rx_len) > DEPTH) ? LW'(DEPTH) : sie_rx_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pipe: '0, dir_tx: 1'b1, holder: HOLDER_BUS, settle: 1'b0,
                     cnt: '0, rx_len: '0, tx_len: '0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rdy      = access_ok;
    assign wr_err   = s_q.err;
    assign rx_len   = s_q.rx_len;
    assign tx_len   = s_q.tx_len;
    assign cur_pipe = s_q.pipe;
    assign sie_own  = s_q.holder == HOLDER_SIE;

    // R2: the cycle after a select never offers the port
    a_r2_settle: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> !rdy);

    // R3: a write reaching the limit hands the buffer over at once
    a_r3_commit_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_next >= lim_x) |=> (sie_own && tx_len == $past(wr_next[LW-1:0])));

    // R3: the count never runs past the buffer
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cnt) <= DEPTH);

    // R7: a sent packet returns an empty buffer to the bus
    a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && sie_done && s_q.dir_tx && sie_own) |=> (!sie_own && s_q.cnt == '0));

    // R8: reading the final byte releases the buffer
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && rd_next >= rxl_x) |=> sie_own);

    // R9: an empty received packet stays with the bus until cleared
    a_r9_zlp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.dir_tx && !sie_own && rx_len == '0 && quiet) |=> !sie_own);

    // R10: the error flag is sticky until a clear or a new select
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && quiet) |=> wr_err);

endmodule

// File: rtl/usb_pkt_port.sv
module usb_pkt_port #(
    parameter int DEPTH = 64,
    parameter int PIPES = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(PIPES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_we,
    input  logic [PW-1:0] sel_pipe,
    input  logic          pipe_dir_tx,
    input  logic          ctrl_dir_tx,
    input  logic          wide16,
    input  logic          dma_mode,
    input  logic [LW-1:0] max_pkt,
    input  logic          wr_en,
    input  logic          wr_hi_en,
    input  logic [15:0]   wr_data,
    input  logic          rd_en,
    output logic [15:0]   rd_data,
    input  logic          wend,
    input  logic          dma_end,
    input  logic          bclr,
    output logic          rdy,
    output logic          wr_err,
    output logic [LW-1:0] rx_len,
    output logic [PW-1:0] cur_pipe,
    output logic          sie_own,
    output logic [LW-1:0] tx_len,
    input  logic          sie_done,
    input  logic          sie_rx_valid,
    input  logic [LW-1:0] sie_rx_len,
    input  logic          sie_we,
    input  logic [AW-1:0] sie_addr,
    input  logic [7:0]    sie_wdata,
    output logic [7:0]    sie_rdata
);

    logic          sie_we_ok, we_lo, we_hi, rd_lo, rd_hi;
    logic [AW-1:0] a_lo, a_hi;
    logic [7:0]    q_lo, q_hi;

    pkt_port_ctrl #(
        .DEPTH(DEPTH), .PIPES(PIPES), .AW(AW), .LW(LW), .PW(PW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_we       (sel_we),
        .sel_pipe     (sel_pipe),
        .pipe_dir_tx  (pipe_dir_tx),
        .ctrl_dir_tx  (ctrl_dir_tx),
        .wide16       (wide16),
        .dma_mode     (dma_mode),
        .max_pkt      (max_pkt),
        .wr_en        (wr_en),
        .wr_hi_en     (wr_hi_en),
        .rd_en        (rd_en),
        .wend         (wend),
        .dma_end      (dma_end),
        .bclr         (bclr),
        .sie_done     (sie_done),
        .sie_rx_valid (sie_rx_valid),
        .sie_rx_len   (sie_rx_len),
        .sie_we_req   (sie_we),
        .sie_we_ok    (sie_we_ok),
        .bus_we_lo    (we_lo),
        .bus_we_hi    (we_hi),
        .rd_lo_en     (rd_lo),
        .rd_hi_en     (rd_hi),
        .addr_lo      (a_lo),
        .addr_hi      (a_hi),
        .rdy          (rdy),
        .wr_err       (wr_err),
        .rx_len       (rx_len),
        .tx_len       (tx_len),
        .cur_pipe     (cur_pipe),
        .sie_own      (sie_own)
    );

    pkt_port_mem #(
        .DEPTH(DEPTH), .AW(AW)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_lo    (we_lo),
        .addr_lo  (a_lo),
        .d_lo     (wr_data[7:0]),
        .we_hi    (we_hi),
        .addr_hi  (a_hi),
        .d_hi     (wr_data[15:8]),
        .sie_we   (sie_we_ok),
        .sie_addr (sie_addr),
        .sie_wd   (sie_wdata),
        .q_lo     (q_lo),
        .q_hi     (q_hi),
        .sie_q    (sie_rdata)
    );

    assign rd_data = {rd_hi ? q_hi : 8'h00, rd_lo ? q_lo : 8'h00};

endmodule

// File: tb/tb_usb_pkt_port.sv
module tb_usb_pkt_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 0, pipe_dir_tx = 0, ctrl_dir_tx = 0, wide16 = 0, dma_mode = 0;
    logic [2:0]  sel_pipe = '0;
    logic [6:0]  max_pkt = '0, sie_rx_len = '0;
    logic        wr_en = 0, wr_hi_en = 0, rd_en = 0, wend = 0, dma_end = 0, bclr = 0;
    logic [15:0] wr_data = '0;
    logic        sie_done = 0, sie_rx_valid = 0, sie_we = 0;
    logic [5:0]  sie_addr = '0;
    logic [7:0]  sie_wdata = '0;
    logic [15:0] rd_data;
    logic        rdy, wr_err, sie_own;
    logic [6:0]  rx_len, tx_len;
    logic [2:0]  cur_pipe;
    logic [7:0]  sie_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] model [64];

    usb_pkt_port dut (.*);

    always #10 clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lim_of(input int mp);
        return (mp == 0 || mp > 64) ? 64 : mp;
    endfunction

    task automatic select(input logic [2:0] p, input logic cdir, input logic pdir);
        sel_we = 1; sel_pipe = p; ctrl_dir_tx = cdir; pipe_dir_tx = pdir;
        cyc();
        sel_we = 0;
    endtask

    task automatic bus_wr(input logic [15:0] d, input logic hi);
        wr_en = 1; wr_data = d; wr_hi_en = hi;
        cyc();
        wr_en = 0; wr_hi_en = 0;
    endtask

    task automatic bus_rd(output logic [15:0] d);
        rd_en = 1;
        #1 d = rd_data;
        cyc();
        rd_en = 0;
    endtask

    task automatic pulse_wend();
        wend = 1; cyc(); wend = 0;
    endtask

    task automatic pulse_bclr();
        bclr = 1; cyc(); bclr = 0;
    endtask

    task automatic pulse_done();
        sie_done = 1; cyc(); sie_done = 0;
    endtask

    task automatic peek(input int a, output logic [7:0] d);
        sie_addr = 6'(a);
        #1 d = sie_rdata;
    endtask

    initial begin
        logic [15:0] rv;
        logic [7:0]  pb;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1 reset state
        check("R1 rdy", rdy, 1);
        check("R1 sie_own", sie_own, 0);
        check("R1 wr_err", wr_err, 0);
        check("R1 rx_len", rx_len, 0);
        check("R1 tx_len", tx_len, 0);
        check("R1 cur_pipe", cur_pipe, 0);
        peek(17, pb);
        check("R1 buffer zero", pb, 0);

        // R2 control pipe transmit via ctrl_dir_tx
        select(3'd0, 1'b1, 1'b0);
        check("R2 settle rdy", rdy, 0);
        cyc();
        check("R2 tx rdy", rdy, 1);

        // R6 16-bit little-endian and odd byte; R4 wend short packet
        wide16 = 1;
        bus_wr(16'hB2A1, 1);
        bus_wr(16'h77C3, 0);
        pulse_wend();
        check("R4 wend commit", sie_own, 1);
        check("R4 tx_len", tx_len, 3);
        peek(0, pb); check("R6 low byte", pb, 8'hA1);
        peek(1, pb); check("R6 high byte", pb, 8'hB2);
        peek(2, pb); check("R6 odd byte", pb, 8'hC3);
        peek(3, pb); check("R6 disabled lane", pb, 8'h00);

        // R10 write and read while SIE holds the buffer
        bus_wr(16'h1111, 1);
        check("R10 err set", wr_err, 1);
        peek(0, pb); check("R10 data untouched", pb, 8'hA1);
        bus_rd(rv);
        check("R10 read zero", rv, 0);
        pulse_bclr();
        check("R10 err cleared", wr_err, 0);

        // R7 return after sent
        pulse_done();
        check("R7 rdy", rdy, 1);
        check("R7 tx_len", tx_len, 0);
        wide16 = 0;
        bus_wr(16'h005A, 0);
        pulse_wend();
        peek(0, pb); check("R7 restart at 0", pb, 8'h5A);
        pulse_done();

        // R5 zero-length transmit
        bus_wr(16'h0001, 0);
        bus_wr(16'h0002, 0);
        pulse_bclr();
        pulse_wend();
        check("R5 zlp own", sie_own, 1);
        check("R5 zlp len", tx_len, 0);
        pulse_done();

        // R4 dma_end gated by dma_mode
        bus_wr(16'h0033, 0);
        dma_end = 1; cyc(); dma_end = 0;
        check("R4 dma_end ignored", sie_own, 0);
        check("R4 dma_end ignored rdy", rdy, 1);
        dma_mode = 1;
        dma_end = 1; cyc(); dma_end = 0;
        check("R4 dma_end commit", sie_own, 1);
        check("R4 dma_end len", tx_len, 1);
        dma_mode = 0;
        pulse_done();

        // R3 limit with a discarded high byte
        max_pkt = 7'd5; wide16 = 1;
        bus_wr(16'h0201, 1);
        bus_wr(16'h0403, 1);
        check("R3 not yet", sie_own, 0);
        bus_wr(16'h0605, 1);
        check("R3 auto commit", sie_own, 1);
        check("R3 rdy low", rdy, 0);
        check("R3 tx_len", tx_len, 5);
        peek(4, pb); check("R3 last byte", pb, 8'h05);
        pulse_done();

        // R3 R6 constrained random transmit packets
        for (int pk = 0; pk < 40; pk++) begin
            int mp, lim, n;
            bit committed;
            mp = (pk % 5 == 0) ? 0 : int'($urandom_range(64, 1));
            max_pkt = 7'(mp);
            lim = lim_of(mp);
            n = 0; committed = 0;
            while (!committed) begin
                if ($urandom_range(15, 0) == 0) begin
                    pulse_wend();
                    committed = 1;
                end else begin
                    logic w, h;
                    logic [15:0] d;
                    int take;
                    w = 1'($urandom_range(1, 0));
                    h = 1'($urandom_range(1, 0));
                    d = 16'($urandom());
                    wide16 = w;
                    take = (w && h && n + 2 <= lim) ? 2 : 1;
                    model[n] = d[7:0];
                    if (take == 2) model[n + 1] = d[15:8];
                    bus_wr(d, h);
                    n += take;
                    if (n >= lim) committed = 1;
                    else check("R3 no early commit", sie_own, 0);
                end
            end
            check("R3 random commit", sie_own, 1);
            check("R3 random tx_len", tx_len, 32'(n));
            for (int i = 0; i < n; i++) begin
                peek(i, pb);
                check("R6 random byte", pb, model[i]);
            end
            pulse_done();
            check("R7 random return", rdy, 1);
        end

        // R2 other pipes follow pipe_dir_tx; R10 on a receive pipe
        select(3'd5, 1'b0, 1'b1);
        cyc();
        check("R2 pipe5 tx", rdy, 1);
        check("R2 cur_pipe", cur_pipe, 5);
        select(3'd3, 1'b1, 1'b0);
        cyc();
        check("R2 rx rdy", rdy, 0);
        check("R2 rx sie_own", sie_own, 1);
        bus_wr(16'h4444, 0);
        check("R10 rx write err", wr_err, 1);
        pulse_bclr();
        select(3'd0, 1'b0, 1'b1);
        cyc();
        check("R2 ctrl rx", sie_own, 1);

        // R8 R9 constrained random receive packets
        for (int pk = 0; pk < 40; pk++) begin
            int len, p;
            len = (pk % 7 == 3) ? 0 : int'($urandom_range(64, 1));
            if (pk == 1) len = 63;
            for (int i = 0; i < len; i++) begin
                model[i] = 8'($urandom());
                sie_we = 1; sie_addr = 6'(i); sie_wdata = model[i];
                cyc();
            end
            sie_we = 0;
            sie_rx_valid = 1; sie_rx_len = 7'(len);
            cyc();
            sie_rx_valid = 0;
            check("R8 rx_len", rx_len, 32'(len));
            check("R8 rdy", rdy, 1);
            if (len == 0) begin
                bus_rd(rv);
                check("R9 zlp read", rv, 0);
                check("R9 zlp held", sie_own, 0);
                pulse_bclr();
                check("R9 bclr release", sie_own, 1);
            end else begin
                p = 0;
                while (p < len) begin
                    logic w;
                    logic [15:0] e;
                    w = 1'($urandom_range(1, 0));
                    wide16 = w;
                    e = {8'h00, model[p]};
                    if (w && p + 1 < len) e[15:8] = model[p + 1];
                    bus_rd(rv);
                    check("R8 read data", rv, e);
                    p += (w && p + 1 < len) ? 2 : 1;
                    if (p < len) check("R8 not released", sie_own, 0);
                end
                check("R8 released", sie_own, 1);
                check("R8 rdy low", rdy, 0);
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule